// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven single-cycle interrupt events from the ports, the timers and the shift register of a peripheral interface into a set of sticky flags. A separate mask decides which flags may raise the shared interrupt line. The line is modelled as a pull-down enable for an open-drain, wire-ORed request signal. A processor reaches both registers over an 8-bit register bus with two chip selects, a read/write strobe and a 4-bit register number. The flag register sits at register 13 and the enable register at register 14. The sources apply their own clear rules and report only set pulses to this block.

A request state machine with two states drives the pull-down. In `REQ_IDLE` the line is released. The transition `idle_to_drive` is taken at the clock edge where at least one flag is both set and enabled. In `REQ_DRIVE` the line is pulled low. The transition `drive_to_idle` is taken at the first edge where no enabled flag remains. Register reads are combinational, and the read data is zero whenever no read of a valid register is selected.

Top module: `irqc_top`

## Requirements
- R1: An asynchronous active-low reset clears every flag and enable bit and releases the request line. After reset the flag register reads 0x00 and the enable register reads 0x80.
- R2: An access takes place only when `cs1_i`=1 and `cs2_ni`=0. Any other combination makes a write have no effect and makes `rdata_o` read 0x00.
- R3: A 1 on `src_set_i[i]` at a clock edge sets flag bit i. The flag stays set until it is cleared.
- R4: A write (`rw_i`=0) to register 13 clears each flag bit i (bits 6:0) whose data bit is 1 and leaves the flag bits written 0 unchanged. Data bit 7 is ignored.
- R5: When a source sets a flag bit in the same cycle that a register-13 write clears it, the flag ends up set.
- R6: A write to register 14 with data bit 7 = 1 sets the enable bits whose data bit (6:0) is 1. With data bit 7 = 0 it clears them. Enable bits written 0 keep their value.
- R7: A read (`rw_i`=1) of register 14 returns bit 7 = 1 and bits 6:0 = the enable bits.
- R8: A read of register 13 returns bits 6:0 = the flags, whether or not they are enabled. Bit 7 is the OR of all flags that are both set and enabled.
- R9: `irq_pull_o` goes to 1 at the clock edge after the one where a set-and-enabled flag first exists. It returns to 0 at the edge after the one where none remains.
- R10: A register number other than 13 or 14 reads 0x00, and a write to it changes no flag and no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| rs_i | input | 4 | Register number |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when no valid read is selected |
| src_set_i | input | 7 | Per-source set pulses |
| irq_pull_o | output | 1 | 1 = pull the shared request line low |

## Verification
A flag bit stuck at the wrong value is visible on the next combinational read of register 13. The same wrong bit also corrupts the summary bit when the flag is enabled. A wrong enable bit shows at once in a register-14 read, and it shows on `irq_pull_o` one clock later. A wrong request state appears on `irq_pull_o` in the first cycle after the pending condition changes. The bench therefore checks each register read right after the stimulus edge and checks the request line one edge after that.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 4;
    localparam int NUM_SRC     = DATA_W - 1;
    localparam logic [ADDR_W-1:0] FLAG_ADDR   = 4'd13;
    localparam logic [ADDR_W-1:0] ENABLE_ADDR = 4'd14;

    typedef enum logic [0:0] {
        REQ_IDLE  = 1'b0,
        REQ_DRIVE = 1'b1
    } req_state_e;
endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
    import irqc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cs1_i,
    input  logic          cs2_ni,
    input  logic          rw_i,
    input  logic [AW-1:0] rs_i,
    input  logic [DW-1:0] flag_view_i,
    input  logic [DW-1:0] en_view_i,
    output logic          wr_flag_o,
    output logic          wr_en_o,
    output logic [DW-1:0] rdata_o
);
    logic sel;
    logic hit_flag;
    logic hit_en;

    assign sel      = cs1_i && !cs2_ni;
    assign hit_flag = (rs_i == FLAG_ADDR);
    assign hit_en   = (rs_i == ENABLE_ADDR);

    assign wr_flag_o = sel && !rw_i && hit_flag;
    assign wr_en_o   = sel && !rw_i && hit_en;

    always_comb begin
        rdata_o = '0;
        if (sel && rw_i) begin
            if (hit_flag)
                rdata_o = flag_view_i;
            else if (hit_en)
                rdata_o = en_view_i;
        end
    end

    // R2 / R10: at most one register is written per cycle
    a_r10_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({wr_flag_o, wr_en_o}));

    // R2: a deselected bus never returns data
    a_r2_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cs1_i && !cs2_ni) |-> (rdata_o == '0));
endmodule

// File: rtl/irqc_flag_reg.sv
module irqc_flag_reg
    import irqc_pkg::*;
#(
    parameter int NS = NUM_SRC
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NS-1:0] src_set_i,
    input  logic          wr_clr_i,
    input  logic [NS-1:0] clr_bits_i,
    output logic [NS-1:0] flags_o
);
    logic [NS-1:0] flags_q;

    for (genvar g = 0; g < NS; g++) begin : g_flag
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                flags_q[g] <= 1'b0;
            else if (src_set_i[g])
                flags_q[g] <= 1'b1;
            else if (wr_clr_i && clr_bits_i[g])
                flags_q[g] <= 1'b0;
        end
    end

    assign flags_o = flags_q;

    // R3 / R5: every pulsed source is set one edge later, even under a clear
    a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|src_set_i) |=> ((flags_q & $past(src_set_i)) == $past(src_set_i)));

    // R4: bits written 1 without a concurrent set are gone after the edge
    a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_clr_i |=> ((flags_q & $past(clr_bits_i & ~src_set_i)) == '0));

    // R4: bits neither set nor cleared keep their value
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_clr_i |=> ((flags_q & ~$past(src_set_i)) == ($past(flags_q) & ~$past(src_set_i))));
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg
    import irqc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NS = NUM_SRC
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [NS-1:0] en_o
);
    localparam int MODE_BIT = DW - 1;

    logic [NS-1:0] en_q;
    logic [NS-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            if (wdata_i[MODE_BIT])
                en_d = en_q | wdata_i[NS-1:0];
            else
                en_d = en_q & ~wdata_i[NS-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            en_q <= '0;
        else
            en_q <= en_d;
    end

    assign en_o = en_q;

    // R6: set form raises every marked bit
    a_r6_set_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && wdata_i[MODE_BIT]) |=>
            ((en_q & $past(wdata_i[NS-1:0])) == $past(wdata_i[NS-1:0])));

    // R6: clear form drops every marked bit
    a_r6_clear_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wdata_i[MODE_BIT]) |=> ((en_q & $past(wdata_i[NS-1:0])) == '0));

    // R6: unmarked bits are untouched
    a_r6_unmarked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((en_q & ~$past(wdata_i[NS-1:0])) == ($past(en_q) & ~$past(wdata_i[NS-1:0]))));
endmodule

// File: rtl/irqc_req_fsm.sv
module irqc_req_fsm
    import irqc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pending_i,
    output logic pull_o
);
    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= REQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pull_o  = 1'b0;
        unique case (state_q)
            REQ_IDLE: begin
                if (pending_i)
                    state_d = REQ_DRIVE;        // idle_to_drive
            end
            REQ_DRIVE: begin
                pull_o = 1'b1;
                if (!pending_i)
                    state_d = REQ_IDLE;         // drive_to_idle
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    // R9: a pending condition drives the line one edge later
    a_r9_assert_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pending_i |=> pull_o);

    // R9: no pending condition releases the line one edge later
    a_r9_release_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pending_i |=> !pull_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cs1_i,
    input  logic               cs2_ni,
    input  logic               rw_i,
    input  logic [ADDR_W-1:0]  rs_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_SRC-1:0] src_set_i,
    output logic               irq_pull_o
);
    logic               wr_flag;
    logic               wr_en;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] enables;
    logic               pending;
    logic [DATA_W-1:0]  flag_view;
    logic [DATA_W-1:0]  en_view;

    assign pending   = |(flags & enables);
    assign flag_view = {pending, flags};
    assign en_view   = {1'b1, enables};

    irqc_bus_decode #(.DW(DATA_W), .AW(ADDR_W)) u_decode (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs1_i       (cs1_i),
        .cs2_ni      (cs2_ni),
        .rw_i        (rw_i),
        .rs_i        (rs_i),
        .flag_view_i (flag_view),
        .en_view_i   (en_view),
        .wr_flag_o   (wr_flag),
        .wr_en_o     (wr_en),
        .rdata_o     (rdata_o)
    );

    irqc_flag_reg #(.NS(NUM_SRC)) u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_set_i  (src_set_i),
        .wr_clr_i   (wr_flag),
        .clr_bits_i (wdata_i[NUM_SRC-1:0]),
        .flags_o    (flags)
    );

    irqc_enable_reg #(.DW(DATA_W), .NS(NUM_SRC)) u_enables (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_en),
        .wdata_i (wdata_i),
        .en_o    (enables)
    );

    irqc_req_fsm u_req (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pending_i (pending),
        .pull_o    (irq_pull_o)
    );

    // R2: without a valid select the mask never moves
    a_r2_no_mask_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cs1_i && !cs2_ni) |=> (enables == $past(enables)));

    // R10: a write to another register number leaves the mask alone
    a_r10_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rs_i != FLAG_ADDR && rs_i != ENABLE_ADDR) |=> (enables == $past(enables)));
endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs1 = 1'b0;
    logic       cs2n = 1'b1;
    logic       rw = 1'b1;
    logic [3:0] rs = 4'd0;
    logic [7:0] wd = 8'd0;
    logic [7:0] rdata;
    logic [6:0] src = 7'd0;
    logic       pull;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqc_top u_irqc_top (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cs1_i      (cs1),
        .cs2_ni     (cs2n),
        .rw_i       (rw),
        .rs_i       (rs),
        .wdata_i    (wd),
        .rdata_o    (rdata),
        .src_set_i  (src),
        .irq_pull_o (pull)
    );

    typedef struct packed {
        logic       cs1;
        logic       cs2n;
        logic       rw;
        logic [3:0] rs;
        logic [7:0] wd;
        logic [6:0] src;
        logic [7:0] exp_flag;
        logic [7:0] exp_en;
        logic       exp_pull;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 4'd0,  8'h00, 7'h05, 8'h05, 8'h80, 1'b0}, // R3 pulse sets flags
        '{1'b1, 1'b0, 1'b0, 4'd14, 8'h81, 7'h00, 8'h85, 8'h81, 1'b1}, // R6 set form
        '{1'b1, 1'b0, 1'b0, 4'd13, 8'h01, 7'h00, 8'h04, 8'h81, 1'b0}, // R4 clear one flag
        '{1'b1, 1'b0, 1'b0, 4'd14, 8'h86, 7'h00, 8'h84, 8'h87, 1'b1}, // R6 R8 summary
        '{1'b1, 1'b0, 1'b0, 4'd13, 8'h04, 7'h04, 8'h84, 8'h87, 1'b1}, // R5 set beats clear
        '{1'b1, 1'b0, 1'b0, 4'd14, 8'h05, 7'h00, 8'h04, 8'h82, 1'b0}, // R6 clear form
        '{1'b0, 1'b0, 1'b0, 4'd14, 8'hFF, 7'h00, 8'h04, 8'h82, 1'b0}, // R2 cs1 low
        '{1'b1, 1'b1, 1'b0, 4'd13, 8'h7F, 7'h00, 8'h04, 8'h82, 1'b0}, // R2 cs2 high
        '{1'b1, 1'b0, 1'b0, 4'd5,  8'hFF, 7'h00, 8'h04, 8'h82, 1'b0}, // R10 other register
        '{1'b0, 1'b0, 1'b1, 4'd0,  8'h00, 7'h42, 8'hC6, 8'h82, 1'b1}, // R3 R8 more sources
        '{1'b1, 1'b0, 1'b0, 4'd13, 8'hFF, 7'h00, 8'h00, 8'h82, 1'b0}, // R4 clear all
        '{1'b1, 1'b0, 1'b0, 4'd14, 8'hFF, 7'h00, 8'h00, 8'hFF, 1'b0}  // R7 full mask read
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] addr, output logic [7:0] val);
        cs1 = 1'b1; cs2n = 1'b0; rw = 1'b1; rs = addr; wd = 8'h00;
        #1;
        val = rdata;
    endtask

    task automatic wr(input logic [3:0] addr, input logic [7:0] val);
        cs1 = 1'b1; cs2n = 1'b0; rw = 1'b0; rs = addr; wd = val;
        tick();
        rw = 1'b1; wd = 8'h00;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        rd(4'd13, v); chk("R1 flags in reset", v, 8'h00);
        rd(4'd14, v); chk("R1 enables in reset", v, 8'h80);
        chk("R1 line in reset", {7'd0, pull}, 8'h00);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            cs1 = VECS[i].cs1; cs2n = VECS[i].cs2n; rw = VECS[i].rw;
            rs = VECS[i].rs; wd = VECS[i].wd; src = VECS[i].src;
            tick();
            src = 7'd0;
            rd(4'd13, v); chk($sformatf("R8 vec %0d flag read", i), v, VECS[i].exp_flag);
            rd(4'd14, v); chk($sformatf("R7 vec %0d enable read", i), v, VECS[i].exp_en);
            tick();
            chk($sformatf("R9 vec %0d request line", i), {7'd0, pull}, {7'd0, VECS[i].exp_pull});
        end

        // R2: deselected read returns zero
        cs1 = 1'b0; cs2n = 1'b0; rw = 1'b1; rs = 4'd14; #1;
        chk("R2 deselected read", rdata, 8'h00);
        cs1 = 1'b1; cs2n = 1'b1; #1;
        chk("R2 cs2 high read", rdata, 8'h00);
        // R10: other register reads zero
        rd(4'd2, v); chk("R10 other register read", v, 8'h00);

        // R9: one-cycle latency of the line, mask is 0x7F here
        src = 7'h10;
        tick();
        src = 7'd0;
        chk("R9 line still released", {7'd0, pull}, 8'h00);
        rd(4'd13, v); chk("R8 summary with flag 4", v, 8'h90);
        tick();
        chk("R9 line driven", {7'd0, pull}, 8'h01);
        wr(4'd13, 8'h10);
        chk("R9 line lags the clear", {7'd0, pull}, 8'h01);
        tick();
        chk("R9 line released", {7'd0, pull}, 8'h00);

        // R1: reset in the middle of activity
        src = 7'h7F;
        tick();
        src = 7'd0;
        tick();
        chk("R1 line before reset", {7'd0, pull}, 8'h01);
        rst_n = 1'b0; #1;
        rd(4'd13, v); chk("R1 flags after reset", v, 8'h00);
        rd(4'd14, v); chk("R1 enables after reset", v, 8'h80);
        chk("R1 line after reset", {7'd0, pull}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        src = 7'h01;
        tick();
        src = 7'd0;
        tick();
        chk("R1 mask stays clear after reset", {7'd0, pull}, 8'h00);
        rd(4'd13, v); chk("R3 flag set after reset", v, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule